// File: doc/BRIEF.md
# Event Time-Stamp Capture

This block records the moment an external event happens. It watches an asynchronous event input and, on its first rising edge, copies six fields of the running calendar clock into a bank of stamp registers. The six fields are seconds, minutes, hours, day of month, month and year, all in packed BCD. In the same cycle it raises an event flag and, if enabled, drives an active-low detect pin.

Software reads the stamp and the flag through a small register read port. It clears the flag with a write to the status address. Once the flag is set, the bank is locked, so only the first event of a burst is recorded. Clearing the flag re-arms the capture. It does not wipe the stored stamp, which only a power-on reset returns to zero.

Top module: `evstamp_top`

## Requirements
- R1: The event input passes through `SYNC_STAGES` flops, and an event is a low-to-high change of the synchronized level. With the default of 2, an input that rises before clock edge 1 updates the flag and the stamp at edge 3. An input held high counts as one event only.
- R2: A captured event loads the live time into the bank. It reads back at `REG_BASE`+k, where k=0 is seconds, 1 minutes, 2 hours, 3 day of month, 4 month and 5 year. `stamp_flat[8k+7:8k]` holds the same field.
- R3: The status register at `STAT_ADDR` carries the event flag in bit 0, and its other bits read 0. A capture sets the flag, and `evt_flag` mirrors it.
- R4: While the flag is set, later rising edges change neither the stamp nor the flag.
- R5: A write to `STAT_ADDR` with `wr_evt`=0 clears the flag. A write with `wr_evt`=1 leaves it unchanged. Neither write alters the stamp.
- R6: After the flag is cleared, the next event overwrites the stamp with the then-current time.
- R7: When a flag clear and a rising edge meet in one cycle, the clear is applied first and the edge is captured. The flag ends set and the stamp holds the new time.
- R8: `evdet_n` goes low at a capture if `evdet_en` is 1 in that cycle, and stays high if it is 0. It returns high when the flag is cleared.
- R9: Writes to the stamp addresses have no effect on the stamp or the flag.
- R10: Reset zeroes the stamp and the flag and drives `evdet_n` high. Addresses outside the bank and the status register read 0, including `REG_BASE`+6, where no day-of-week field exists.
- R11: A falling edge of the event input is not an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| evin | input | 1 | Asynchronous event input |
| evdet_en | input | 1 | Enables the detect pin at capture |
| time_sec | input | 8 | Live seconds, BCD |
| time_min | input | 8 | Live minutes, BCD |
| time_hr | input | 8 | Live hours, BCD |
| time_date | input | 8 | Live day of month, BCD |
| time_mon | input | 8 | Live month, BCD |
| time_yr | input | 8 | Live year, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_evt | input | 1 | Value written to the flag bit |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Read data, combinational |
| evt_flag | output | 1 | Event flag |
| evdet_n | output | 1 | Active-low event detect pin |
| stamp_flat | output | 48 | All six stamp fields |

## Verification
The bench builds the block with its defaults: a two-flop synchronizer, the bank at 14h and status at 0Fh. With these values the three-edge latency from input to flag can be checked at an exact cycle. They also place the unused address 1Ah directly past the bank, so its read-back can be tested. The clear-and-edge collision is hit by timing the status write for the cycle in which the synchronized edge is seen.

// File: rtl/evstamp_pkg.sv
package evstamp_pkg;
    localparam int FIELDS = 6;
    localparam int BCD_W  = 8;
    localparam int STAMP_W = FIELDS * BCD_W;

    typedef logic [BCD_W-1:0] bcd_t;

    typedef struct packed {
        bcd_t yr;
        bcd_t mon;
        bcd_t date;
        bcd_t hr;
        bcd_t min;
        bcd_t sec;
    } stamp_t;

    typedef enum logic {
        EV_ARMED   = 1'b0,
        EV_LATCHED = 1'b1
    } ev_state_e;

    function automatic bcd_t field_of(input logic [STAMP_W-1:0] flat, input int idx);
        return flat[idx*BCD_W +: BCD_W];
    endfunction
endpackage

// File: rtl/evstamp_sync.sv
module evstamp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic evin,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= evin;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~prev;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise); // R1
endmodule

// File: rtl/evstamp_ctrl.sv
module evstamp_ctrl
    import evstamp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic clr_req,
    input  logic det_en,
    output logic capture,
    output logic evt,
    output logic evdet_n
);
    ev_state_e state;

    assign capture = rise && ((state == EV_ARMED) || clr_req);
    assign evt     = (state == EV_LATCHED);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= EV_ARMED;
            evdet_n <= 1'b1;
        end else if (capture) begin
            state   <= EV_LATCHED;
            evdet_n <= ~det_en;
        end else if (clr_req) begin
            state   <= EV_ARMED;
            evdet_n <= 1'b1;
        end
    end

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (evt && !clr_req) |=> evt); // R4
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !rise) |=> !evt); // R5
    AST_CLEAR_THEN_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (clr_req && rise) |=> evt); // R7
    AST_DETECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        !evt |-> evdet_n); // R8
endmodule

// File: rtl/evstamp_bank.sv
module evstamp_bank #(
    parameter int FIELDS = 6,
    parameter int W      = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                capture,
    input  logic [FIELDS*W-1:0] live,
    output logic [FIELDS*W-1:0] stamp
);
    for (genvar k = 0; k < FIELDS; k++) begin : g_field
        always_ff @(posedge clk) begin
            if (rst)          stamp[k*W +: W] <= '0;
            else if (capture) stamp[k*W +: W] <= live[k*W +: W];
        end
    end

    AST_STAMP_LOAD: assert property (@(posedge clk) disable iff (rst)
        capture |=> (stamp == $past(live))); // R2
    AST_STAMP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(stamp)); // R9
endmodule

// File: rtl/evstamp_top.sv
module evstamp_top
    import evstamp_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_BASE    = 8'h14,
    parameter logic [ADDR_W-1:0] STAT_ADDR   = 8'h0F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evin,
    input  logic              evdet_en,
    input  logic [7:0]        time_sec,
    input  logic [7:0]        time_min,
    input  logic [7:0]        time_hr,
    input  logic [7:0]        time_date,
    input  logic [7:0]        time_mon,
    input  logic [7:0]        time_yr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_evt,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              evt_flag,
    output logic              evdet_n,
    output logic [47:0]       stamp_flat
);
    stamp_t live;
    logic   rise;
    logic   capture;
    logic   clr_req;
    logic [ADDR_W-1:0] rd_off;

    always_comb begin
        live.sec  = time_sec;
        live.min  = time_min;
        live.hr   = time_hr;
        live.date = time_date;
        live.mon  = time_mon;
        live.yr   = time_yr;
    end

    assign clr_req = wr_en && (wr_addr == STAT_ADDR) && !wr_evt;

    evstamp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .evin (evin),
        .rise (rise)
    );

    evstamp_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .rise    (rise),
        .clr_req (clr_req),
        .det_en  (evdet_en),
        .capture (capture),
        .evt     (evt_flag),
        .evdet_n (evdet_n)
    );

    evstamp_bank #(.FIELDS(FIELDS), .W(BCD_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .live    (live),
        .stamp   (stamp_flat)
    );

    assign rd_off = rd_addr - REG_BASE;

    always_comb begin
        rd_data = '0;
        if (rd_addr == STAT_ADDR) begin
            rd_data = {7'b0, evt_flag};
        end else if (rd_addr >= REG_BASE) begin
            for (int k = 0; k < FIELDS; k++) begin
                if (rd_off == ADDR_W'(k)) rd_data = field_of(stamp_flat, k);
            end
        end
    end

    AST_RESET_CLEAN: assert property (@(posedge clk)
        rst |=> (!evt_flag && evdet_n && stamp_flat == '0)); // R10
    AST_STATUS_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == STAT_ADDR) |-> (rd_data == {7'b0, evt_flag})); // R3
endmodule

// File: tb/evstamp_top_tb.sv
module evstamp_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evin = 1'b0;
    logic        evdet_en = 1'b0;
    logic [47:0] live = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic        wr_evt = 1'b1;
    logic [7:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        evt_flag;
    logic        evdet_n;
    logic [47:0] stamp_flat;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    evstamp_top u_dut (
        .clk(clk), .rst(rst), .evin(evin), .evdet_en(evdet_en),
        .time_sec(live[7:0]), .time_min(live[15:8]), .time_hr(live[23:16]),
        .time_date(live[31:24]), .time_mon(live[39:32]), .time_yr(live[47:40]),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_evt(wr_evt),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .evt_flag(evt_flag), .evdet_n(evdet_n), .stamp_flat(stamp_flat)
    );

    // bit 48: detect enable, bits 47:0: yr mon date hr min sec (BCD)
    localparam logic [48:0] VEC [4] = '{
        {1'b1, 48'h99_12_31_23_59_59},
        {1'b0, 48'h00_01_01_00_00_00},
        {1'b1, 48'h24_06_15_11_30_07},
        {1'b0, 48'h10_07_04_18_45_22}
    };

    task automatic chk(input string tag, input logic [47:0] got, input logic [47:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic read_bank(output logic [47:0] s);
        logic [7:0] d;
        for (int k = 0; k < 6; k++) begin
            rd(8'h14 + 8'(k), d);
            s[k*8 +: 8] = d;
        end
    endtask

    task automatic status_write(input logic [7:0] a, input logic v);
        wr_en = 1'b1; wr_addr = a; wr_evt = v;
        step(1);
        wr_en = 1'b0; wr_evt = 1'b1;
    endtask

    task automatic pulse_event();
        evin = 1'b1;
        step(5);
        evin = 1'b0;
        step(4);
    endtask

    initial begin
        logic [47:0] s;
        logic [7:0]  d;
        live = 48'h55_05_05_05_05_05;
        step(3);
        rst = 1'b0;
        step(1);
        // reset state
        read_bank(s);
        chk("R10 stamp after reset", s, 48'h0);
        chk("R10 stamp_flat after reset", stamp_flat, 48'h0);
        rd(8'h0F, d);
        chk("R10 status after reset", {40'h0, d}, 48'h0);
        chk("R10 evdet_n after reset", {47'h0, evdet_n}, 48'h1);
        rd(8'h1A, d);
        chk("R10 addr 1Ah reads 0", {40'h0, d}, 48'h0);

        // table walk
        for (int i = 0; i < 4; i++) begin
            status_write(8'h0F, 1'b0);
            live = VEC[i][47:0];
            evdet_en = VEC[i][48];
            evin = 1'b1;
            step(2);
            chk("R1 no flag before edge 3", {47'h0, evt_flag}, 48'h0);
            step(1);
            chk("R3 flag set at edge 3", {47'h0, evt_flag}, 48'h1);
            rd(8'h0F, d);
            chk("R3 status bit0", {40'h0, d}, 48'h1);
            chk("R8 evdet_n level", {47'h0, evdet_n}, {47'h0, ~VEC[i][48]});
            read_bank(s);
            chk("R2 R6 stamp read-back", s, VEC[i][47:0]);
            chk("R2 stamp_flat", stamp_flat, VEC[i][47:0]);
            live = 48'h77_07_07_07_07_07;
            step(4);
            chk("R1 held level one event", stamp_flat, VEC[i][47:0]);
            evin = 1'b0;
            step(4);
        end

        // R4: second event ignored while flag set
        live = 48'h01_02_03_04_05_06;
        pulse_event();
        chk("R4 stamp kept", stamp_flat, VEC[3][47:0]);
        chk("R4 flag kept", {47'h0, evt_flag}, 48'h1);

        // R9: writes to stamp addresses
        status_write(8'h14, 1'b0);
        status_write(8'h19, 1'b0);
        chk("R9 stamp unchanged", stamp_flat, VEC[3][47:0]);
        chk("R9 flag unchanged", {47'h0, evt_flag}, 48'h1);

        // R5: writing 1 does nothing, writing 0 clears
        status_write(8'h0F, 1'b1);
        chk("R5 write 1 keeps flag", {47'h0, evt_flag}, 48'h1);
        evdet_en = 1'b1;
        live = 48'h21_03_09_08_07_06;
        status_write(8'h0F, 1'b0);
        evin = 1'b0;
        step(2);
        evin = 1'b1;
        step(3);
        chk("R8 evdet_n low with enable", {47'h0, evdet_n}, 48'h0);
        step(2);
        status_write(8'h0F, 1'b0);
        chk("R5 flag cleared", {47'h0, evt_flag}, 48'h0);
        chk("R8 evdet_n released", {47'h0, evdet_n}, 48'h1);
        chk("R5 stamp retained", stamp_flat, 48'h21_03_09_08_07_06);

        // R11: falling edge with flag clear
        live = 48'h33_03_03_03_03_03;
        evin = 1'b0;
        step(5);
        chk("R11 fall not an event", {47'h0, evt_flag}, 48'h0);
        chk("R11 stamp retained", stamp_flat, 48'h21_03_09_08_07_06);

        // R7: clear and edge in the same cycle
        live = 48'h44_04_04_04_04_04;
        pulse_event();
        chk("R7 setup flag", {47'h0, evt_flag}, 48'h1);
        live = 48'h45_05_06_07_08_09;
        evin = 1'b1;
        step(2);
        wr_en = 1'b1; wr_addr = 8'h0F; wr_evt = 1'b0;
        step(1);
        wr_en = 1'b0; wr_evt = 1'b1;
        chk("R7 flag stays set", {47'h0, evt_flag}, 48'h1);
        chk("R7 new stamp", stamp_flat, 48'h45_05_06_07_08_09);
        evin = 1'b0;
        step(3);

        // R10: reset mid-run
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(1);
        chk("R10 stamp wiped", stamp_flat, 48'h0);
        chk("R10 flag wiped", {47'h0, evt_flag}, 48'h0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule